// File: doc/BRIEF.md
# Stripmine Vector Length Setter

This block turns a requested application vector length into the active vector length that a stripmined loop processes next. It takes an unsigned XLEN-bit requested length and the maximum vector length of the current configuration. When the request exceeds the maximum but is below twice the maximum, the block splits the remainder in half, rounding up. The last two passes of the loop are then balanced, and the lengths never increase from one pass to the next.

The chosen length is returned on a result port one cycle after the request is accepted. It is also written into a held length register. A configuration write reloads that register with the maximum length. With each result the block also issues a tail range for the register file: a start index and an enable. Elements from that start index up to the maximum must be cleared. When the chosen length is zero, no tail range is issued.

Top module: `strip_len_unit`

## Requirements
- R1: When the request is at least twice the maximum length, the result is the maximum length. This includes the all-ones request, and the comparison does not overflow.
- R2: When the request is strictly greater than the maximum but strictly less than twice the maximum, the result is the request divided by two, rounded up.
- R3: When the request is at most the maximum length, the result equals the request.
- R4: A request accepted on one rising edge raises `resValid` for exactly one cycle, starting at the next edge. In that same cycle `resVl` and `vlHeld` both carry the result.
- R5: The result never exceeds the maximum length that was applied with the request.
- R6: When `cfgWrite` is high on an edge, `vlHeld` takes the value of `mvl` at that edge. A request in the same cycle is discarded and produces no `resValid`.
- R7: In a result cycle where the result is non-zero and below the maximum, `tailEn` is high and `tailStart` equals the result. In any other cycle `tailEn` is low.
- R8: When the result is zero, `tailEn` stays low, so the destination is left untouched.
- R9: While reset is held, and after its release, `resValid`, `tailEn` and `vlHeld` are zero until the first accepted request or configuration write.
- R10: Between accepted requests and configuration writes, `vlHeld` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqAvl | input | XLEN | Requested application vector length, unsigned |
| mvl | input | XLEN | Maximum vector length of the current configuration |
| cfgWrite | input | 1 | Configuration write; reloads the held length from `mvl` |
| resValid | output | 1 | Result strobe, one cycle per accepted request |
| resVl | output | XLEN | Chosen active vector length |
| vlHeld | output | XLEN | Held active vector length register |
| tailEn | output | 1 | Tail clear range valid |
| tailStart | output | XLEN | First element index to be cleared |

## Verification
Every result, the tail range and the held length are due one rising edge after the request or configuration write. The bench drives inputs on the falling edge. It lets exactly one rising edge pass and samples at the following falling edge. One falling edge later it checks that `resValid` and `tailEn` have dropped again. The hold checks insert idle cycles and sample `vlHeld` at a falling edge, after several edges with no stimulus.

// File: rtl/strip_len_pkg.sv
package strip_len_pkg;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic loadReq;  // accept a request this edge
    logic loadCfg;  // reload held length from the maximum
  } stripStrobes_t;

endpackage

// File: rtl/strip_len_ctrl.sv
module strip_len_ctrl
  import strip_len_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          cfgWrite,
  output stripStrobes_t strobes,
  output logic          resValid
);

  // Configuration write wins; a coinciding request is dropped.
  always_comb begin
    strobes.loadCfg = cfgWrite;
    strobes.loadReq = reqValid && !cfgWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
    end else begin
      resValid <= strobes.loadReq;
    end
  end

endmodule

// File: rtl/strip_len_dp.sv
module strip_len_dp
  import strip_len_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter bit BALANCE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  stripStrobes_t     strobes,
  input  logic [XLEN-1:0]   reqAvl,
  input  logic [XLEN-1:0]   mvl,
  output logic [XLEN-1:0]   resVl,
  output logic [XLEN-1:0]   vlHeld,
  output logic              tailEn,
  output logic [XLEN-1:0]   tailStart
);

  localparam int WIDE = XLEN + 1;

  logic [WIDE-1:0] avlWide;
  logic [WIDE-1:0] mvlTwice;
  logic [WIDE-1:0] halfUp;
  logic [XLEN-1:0] nextVl;
  logic            nextTail;

  // One extra bit keeps 2*max and avl+1 free of overflow
  assign avlWide  = {1'b0, reqAvl};
  assign mvlTwice = {mvl, 1'b0};
  assign halfUp   = (avlWide + WIDE'(1)) >> 1;

  generate
    if (BALANCE) begin : g_balanced
      always_comb begin
        if (avlWide >= mvlTwice) begin
          nextVl = mvl;
        end else if (reqAvl > mvl) begin
          nextVl = halfUp[XLEN-1:0];
        end else begin
          nextVl = reqAvl;
        end
      end
    end else begin : g_plainMin
      always_comb begin
        nextVl = (reqAvl > mvl) ? mvl : reqAvl;
      end
    end
  endgenerate

  assign nextTail = (nextVl != '0) && (nextVl < mvl);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resVl     <= '0;
      vlHeld    <= '0;
      tailEn    <= 1'b0;
      tailStart <= '0;
    end else begin
      tailEn <= 1'b0;
      if (strobes.loadCfg) begin
        vlHeld <= mvl;
      end else if (strobes.loadReq) begin
        vlHeld    <= nextVl;
        resVl     <= nextVl;
        tailStart <= nextVl;
        tailEn    <= nextTail;
      end
    end
  end

endmodule

// File: rtl/strip_len_unit.sv
module strip_len_unit
  import strip_len_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter bit BALANCE = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [XLEN-1:0] reqAvl,
  input  logic [XLEN-1:0] mvl,
  input  logic            cfgWrite,
  output logic            resValid,
  output logic [XLEN-1:0] resVl,
  output logic [XLEN-1:0] vlHeld,
  output logic            tailEn,
  output logic [XLEN-1:0] tailStart
);

  stripStrobes_t strobes;

  strip_len_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .cfgWrite (cfgWrite),
    .strobes  (strobes),
    .resValid (resValid)
  );

  strip_len_dp #(
    .XLEN    (XLEN),
    .BALANCE (BALANCE)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqAvl    (reqAvl),
    .mvl       (mvl),
    .resVl     (resVl),
    .vlHeld    (vlHeld),
    .tailEn    (tailEn),
    .tailStart (tailStart)
  );

endmodule

// File: rtl/strip_len_checker.sv
module strip_len_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic [XLEN-1:0] reqAvl,
  input logic [XLEN-1:0] mvl,
  input logic            cfgWrite,
  input logic            resValid,
  input logic [XLEN-1:0] resVl,
  input logic [XLEN-1:0] vlHeld,
  input logic            tailEn,
  input logic [XLEN-1:0] tailStart
);

  assert_result_follows_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !cfgWrite) |=> resValid);

  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !cfgWrite) |=> !resValid);

  assert_held_matches_R4: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (vlHeld == resVl));

  assert_within_max_R5: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resVl <= $past(mvl)));

  assert_cfg_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> (vlHeld == $past(mvl) && !resValid));

  assert_tail_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    tailEn |-> (resValid && tailStart == resVl && resVl < $past(mvl)));

  assert_zero_no_tail_R8: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resVl == '0) |-> !tailEn);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid && !cfgWrite) |=> $stable(vlHeld));

endmodule

bind strip_len_unit strip_len_checker #(.XLEN(XLEN)) i_checker (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqAvl    (reqAvl),
  .mvl       (mvl),
  .cfgWrite  (cfgWrite),
  .resValid  (resValid),
  .resVl     (resVl),
  .vlHeld    (vlHeld),
  .tailEn    (tailEn),
  .tailStart (tailStart)
);

// File: tb/test_strip_len_unit.sv
module test_strip_len_unit;

  localparam int XLEN = 32;
  localparam int WATCHDOG_CYCLES = 100000;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic [XLEN-1:0] reqAvl = '0;
  logic [XLEN-1:0] mvl = '0;
  logic            cfgWrite = 1'b0;
  logic            resValid;
  logic [XLEN-1:0] resVl;
  logic [XLEN-1:0] vlHeld;
  logic            tailEn;
  logic [XLEN-1:0] tailStart;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  strip_len_unit #(.XLEN(XLEN)) i_strip_len_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAvl(reqAvl), .mvl(mvl),
    .cfgWrite(cfgWrite), .resValid(resValid), .resVl(resVl), .vlHeld(vlHeld),
    .tailEn(tailEn), .tailStart(tailStart)
  );

  function automatic logic [XLEN-1:0] expVl(input logic [XLEN-1:0] a, input logic [XLEN-1:0] m);
    logic [XLEN:0] a1 = {1'b0, a};
    logic [XLEN:0] m2 = {1'b0, m} + {1'b0, m};
    if (a1 >= m2) return m;             // R1
    if (a > m) return XLEN'((a1 + 1) / 2);  // R2
    return a;                           // R3
  endfunction

  function automatic string regionTag(input logic [XLEN-1:0] a, input logic [XLEN-1:0] m);
    logic [XLEN:0] a1 = {1'b0, a};
    logic [XLEN:0] m2 = {1'b0, m} + {1'b0, m};
    if (a1 >= m2) return "R1";
    if (a > m) return "R2";
    return "R3";
  endfunction

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReq(input logic [XLEN-1:0] a, input logic [XLEN-1:0] m);
    logic [XLEN-1:0] e;
    logic tailExp;
    @(negedge clk);
    reqValid = 1'b1; reqAvl = a; mvl = m; cfgWrite = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    e = expVl(a, m);
    tailExp = (e != 0) && (e < m);
    chk(regionTag(a, m), resVl, e);
    chk("R4 valid", XLEN'(resValid), 1);
    chk("R4 held", vlHeld, e);
    chk("R5 bound", XLEN'(resVl <= m), 1);
    chk(e == 0 ? "R8 tailEn" : "R7 tailEn", XLEN'(tailEn), XLEN'(tailExp));
    if (tailExp) chk("R7 tailStart", tailStart, e);
    @(negedge clk);
    chk("R4 pulse", XLEN'(resValid), 0);
    chk("R7 tail drop", XLEN'(tailEn), 0);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
      finishRun();
    end
  end

  initial begin : stimulus
    logic [XLEN-1:0] held;
    logic [XLEN-1:0] a;
    logic [XLEN-1:0] m;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 valid", XLEN'(resValid), 0);
    chk("R9 held", vlHeld, 0);
    chk("R9 tail", XLEN'(tailEn), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 after release", vlHeld, 0);

    // Directed corners
    doReq(0, 16);               // R8
    doReq(16, 16);              // R3 equal
    doReq(17, 16);              // R2 -> 9
    doReq(31, 16);              // R2 -> 16
    doReq(32, 16);              // R1 boundary
    doReq('1, 16);              // R1 all ones
    doReq('1, '1);              // R1 all ones both
    doReq(32'h8000_0001, 32'h8000_0000); // R2 near overflow
    doReq(5, 16);               // R3 with tail
    doReq(7, 0);                // R1 zero max
    doReq(1, 1);                // R3

    // R10: hold across idle cycles
    held = vlHeld;
    repeat (5) @(negedge clk);
    chk("R10 hold", vlHeld, held);

    // R6: configuration write
    @(negedge clk);
    cfgWrite = 1'b1; mvl = 24;
    @(negedge clk);
    cfgWrite = 1'b0;
    chk("R6 reload", vlHeld, 24);
    chk("R6 no result", XLEN'(resValid), 0);

    // R6: coinciding request dropped
    @(negedge clk);
    cfgWrite = 1'b1; reqValid = 1'b1; reqAvl = 3; mvl = 40;
    @(negedge clk);
    cfgWrite = 1'b0; reqValid = 1'b0;
    chk("R6 drop valid", XLEN'(resValid), 0);
    chk("R6 drop held", vlHeld, 40);
    chk("R6 drop tail", XLEN'(tailEn), 0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      m = XLEN'($urandom_range(0, 64));
      case ($urandom_range(0, 3))
        0: a = XLEN'($urandom_range(0, 64));
        1: a = m + XLEN'($urandom_range(0, 64));
        2: a = $urandom();
        default: a = XLEN'($urandom_range(0, 200));
      endcase
      doReq(a, m);
    end

    done = 1'b1;
    finishRun();
  end

endmodule